// File: doc/BRIEF.md
# Page Table Translation Unit

This block turns a 14-bit virtual address into a 12-bit physical address by looking up one entry of a page table that sits in memory. Pages are 64 bytes, so the low six address bits are the in-page offset and pass through untouched. The upper eight bits are the virtual page number, which selects one of 256 table entries.

A requester presents a virtual address, an access kind (read or write) and a privilege flag through a valid/ready handshake. The unit adds the page number to a table base value, issues exactly one read on its memory request port, and waits for the returned word. It then checks that the entry is present and that the access is allowed. It reports a physical address, a page fault or a protection fault with a one-cycle response strobe. Only one translation is in flight at any time. Recovering from a fault is left to the surrounding system.

Top module: `ptw_xlat_unit`

## Requirements
- R1: After reset, `req_ready` is 1, and `mem_req_valid` and `rsp_valid` are 0.
- R2: After a request is accepted, the unit raises `mem_req_valid` with `mem_req_addr` equal to `(tbl_base + vaddr[13:6]) mod 2^16`. `tbl_base` is sampled in the acceptance cycle, and later changes have no effect on that request.
- R3: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request and its address stay unchanged. After one accepted memory request, `mem_req_valid` is 0 for the rest of that translation.
- R4: `req_ready` is 1 only when no translation is in flight. A request offered while one is in flight is not taken.
- R5: An entry whose bit 15 (present) is 0 gives `rsp_page_fault`=1, `rsp_prot_fault`=0 and `rsp_paddr`=0, whatever its permission bits hold.
- R6: A present entry with bit 12 (supervisor-only) set gives a protection fault when `req_super` is 0. With `req_super`=1 such a page is accessible.
- R7: A read (`req_write`=0) needs bit 14 of the entry and a write (`req_write`=1) needs bit 13. A missing bit gives a protection fault with `rsp_paddr`=0.
- R8: A permitted access gives `rsp_paddr = {entry[5:0], vaddr[5:0]}` with both fault flags 0.
- R9: `rsp_valid` is a single-cycle pulse in the cycle after `mem_rsp_valid` is seen, and at most one fault flag is set with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_base | input | 16 | Word address of table entry 0 |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_vaddr | input | 14 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_super | input | 1 | 1 = supervisor-mode access |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 16 | Word address of the entry |
| mem_rsp_valid | input | 1 | Returned entry word is valid |
| mem_rsp_data | input | 16 | Returned entry word |
| rsp_valid | output | 1 | Result strobe |
| rsp_paddr | output | 12 | Physical address, 0 on any fault |
| rsp_page_fault | output | 1 | Entry not present |
| rsp_prot_fault | output | 1 | Access not permitted |

## Verification
The bench looks for cases where the fault checks are applied in the wrong order. One case is an absent entry with every permission bit set, which a design that looks at permissions first would report as a success. Another is a supervisor-only page reached from user mode with both read and write bits set, which a design that ignores the privilege flag would translate. It checks that read and write each look at their own bit, so a swapped bit shows up on read-only and write-only pages. It also checks the table address under wraparound (base 0xFFFF plus page 0xFF), a base that changes after acceptance, and a memory that holds off its ready for several cycles, which would expose a dropped or repeated request.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W   = 14;
  localparam int PA_W   = 12;
  localparam int OFS_W  = 6;
  localparam int MEM_AW = 16;
  localparam int MEM_DW = 16;
  localparam int VPN_W  = VA_W - OFS_W;
  localparam int PPN_W  = PA_W - OFS_W;

  // entry word field positions
  localparam int BIT_PRESENT = MEM_DW - 1;
  localparam int BIT_RD      = MEM_DW - 2;
  localparam int BIT_WR      = MEM_DW - 3;
  localparam int BIT_SUPONLY = MEM_DW - 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_AWAIT = 2'd2,
    ST_REPLY = 2'd3
  } walk_state_t;

  typedef struct packed {
    logic             page_fault;
    logic             prot_fault;
    logic [PA_W-1:0]  paddr;
  } xlat_result_t;

  function automatic logic [MEM_AW-1:0] entry_word_addr(
      input logic [MEM_AW-1:0] base, input logic [VPN_W-1:0] vpn);
    logic [MEM_AW-1:0] wide_vpn;
    wide_vpn = MEM_AW'(vpn);
    return base + wide_vpn;
  endfunction

  function automatic xlat_result_t judge_entry(
      input logic [MEM_DW-1:0] ent, input logic is_write,
      input logic is_super, input logic [OFS_W-1:0] ofs);
    xlat_result_t r;
    logic priv_ok, kind_ok;
    priv_ok = is_super | ~ent[BIT_SUPONLY];
    kind_ok = is_write ? ent[BIT_WR] : ent[BIT_RD];
    r.page_fault = ~ent[BIT_PRESENT];
    r.prot_fault = ent[BIT_PRESENT] & ~(priv_ok & kind_ok);
    r.paddr      = (r.page_fault | r.prot_fault) ? '0
                   : {ent[PPN_W-1:0], ofs};
    return r;
  endfunction
endpackage

// File: rtl/ptw_addr_split.sv
module ptw_addr_split
  import ptw_pkg::*;
(
  input  logic [VA_W-1:0]   vaddr,
  input  logic [MEM_AW-1:0] base,
  output logic [VPN_W-1:0]  vpn,
  output logic [OFS_W-1:0]  ofs,
  output logic [MEM_AW-1:0] ent_addr
);
  always_comb begin
    vpn      = vaddr[VA_W-1:OFS_W];
    ofs      = vaddr[OFS_W-1:0];
    ent_addr = entry_word_addr(base, vpn);
  end
endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
  import ptw_pkg::*;
(
  input  logic [MEM_DW-1:0] ent,
  input  logic              is_write,
  input  logic              is_super,
  input  logic [OFS_W-1:0]  ofs,
  output xlat_result_t      res
);
  always_comb res = judge_entry(ent, is_write, is_super, ofs);

  always_comb begin
    if (res.page_fault && res.prot_fault)
      AST_FAULTS_EXCLUSIVE: assert (1'b0) else $error("both faults"); // R9
    if (res.page_fault)
      AST_ABSENT_NO_ADDR: assert (res.paddr == '0) else $error("paddr on absent"); // R5
  end
endmodule

// File: rtl/ptw_walk_ctrl.sv
module ptw_walk_ctrl
  import ptw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic mem_req_valid,
  input  logic mem_req_ready,
  input  logic mem_rsp_valid,
  output logic rsp_valid,
  output logic accept_evt,
  output logic fetch_done_evt
);
  walk_state_t state_q, state_d;

  always_comb begin
    req_ready      = (state_q == ST_IDLE);
    mem_req_valid  = (state_q == ST_ISSUE);
    rsp_valid      = (state_q == ST_REPLY);
    accept_evt     = req_valid && (state_q == ST_IDLE);
    fetch_done_evt = mem_rsp_valid && (state_q == ST_AWAIT);
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid)     state_d = ST_ISSUE;
      ST_ISSUE: if (mem_req_ready) state_d = ST_AWAIT;
      ST_AWAIT: if (mem_rsp_valid) state_d = ST_REPLY;
      ST_REPLY:                    state_d = ST_IDLE;
      default:                     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid) else $error("req dropped"); // R3
  AST_SINGLE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid) else $error("req repeated"); // R3
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || rsp_valid) |-> !req_ready) else $error("ready while busy"); // R4
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid) else $error("rsp longer than one cycle"); // R9
  AST_RSP_FOLLOWS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done_evt |=> rsp_valid) else $error("rsp not after fetch"); // R9
endmodule

// File: rtl/ptw_xlat_unit.sv
module ptw_xlat_unit
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       tbl_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [13:0]       req_vaddr,
  input  logic              req_write,
  input  logic              req_super,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [15:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [15:0]       mem_rsp_data,
  output logic              rsp_valid,
  output logic [11:0]       rsp_paddr,
  output logic              rsp_page_fault,
  output logic              rsp_prot_fault
);
  logic              accept_evt, fetch_done_evt;
  logic [VPN_W-1:0]  vpn_w;
  logic [OFS_W-1:0]  ofs_w;
  logic [MEM_AW-1:0] ent_addr_w;
  logic [MEM_AW-1:0] ent_addr_q;
  logic [OFS_W-1:0]  ofs_q;
  logic              write_q, super_q;
  xlat_result_t      res_w, res_q;

  ptw_addr_split u_split (
    .vaddr(req_vaddr), .base(tbl_base),
    .vpn(vpn_w), .ofs(ofs_w), .ent_addr(ent_addr_w)
  );

  ptw_walk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .rsp_valid(rsp_valid),
    .accept_evt(accept_evt), .fetch_done_evt(fetch_done_evt)
  );

  ptw_entry_check u_check (
    .ent(mem_rsp_data), .is_write(write_q), .is_super(super_q),
    .ofs(ofs_q), .res(res_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_addr_q <= '0;
      ofs_q      <= '0;
      write_q    <= 1'b0;
      super_q    <= 1'b0;
    end else if (accept_evt) begin
      ent_addr_q <= ent_addr_w;
      ofs_q      <= ofs_w;
      write_q    <= req_write;
      super_q    <= req_super;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              res_q <= '0;
    else if (fetch_done_evt) res_q <= res_w;
  end

  always_comb begin
    mem_req_addr   = ent_addr_q;
    rsp_paddr      = res_q.paddr;
    rsp_page_fault = res_q.page_fault;
    rsp_prot_fault = res_q.prot_fault;
  end

  // vpn_w is consumed inside the address split; keep it observable for checks
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> $stable(mem_req_addr)) else $error("addr moved"); // R3
  AST_ADDR_FROM_VPN: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> mem_req_addr == $past(tbl_base) + MEM_AW'($past(vpn_w))) else $error("bad entry addr"); // R2
  AST_ONE_FAULT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_page_fault && rsp_prot_fault)) else $error("two faults"); // R9
  AST_FAULT_ZERO_PADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_page_fault || rsp_prot_fault) |-> rsp_paddr == '0) else $error("paddr on fault"); // R7
endmodule

// File: tb/sim_ptw_xlat_unit.sv
module sim_ptw_xlat_unit;
  timeunit 1ns; timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tbl_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [13:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_super = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [15:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic [11:0] rsp_paddr;
  logic        rsp_page_fault, rsp_prot_fault;

  int n_run = 0;
  int n_fail = 0;
  bit reported = 0;

  always #10 clk = ~clk;

  ptw_xlat_unit u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // expected result packed as {pf, prot, paddr[11:0]}
  function automatic logic [13:0] model(input logic [13:0] va, input logic wr,
                                        input logic sup, input logic [15:0] e);
    if (e[15] == 1'b0) return {2'b10, 12'h000};
    if (e[12] && !sup) return {2'b01, 12'h000};
    if (wr && !e[13])  return {2'b01, 12'h000};
    if (!wr && !e[14]) return {2'b01, 12'h000};
    return {2'b00, e[5:0], va[5:0]};
  endfunction

  task automatic xlat(input logic [13:0] va, input logic wr, input logic sup,
                      input logic [15:0] base, input logic [15:0] ent,
                      input int stall, input int lat, input string tag);
    logic [15:0] exp_addr;
    logic [13:0] exp;
    exp_addr = base + {8'h00, va[13:6]};
    exp = model(va, wr, sup, ent);
    @(negedge clk);
    chk(req_ready === 1'b1, "R4 idle ready", req_ready, 1);
    req_valid = 1; req_vaddr = va; req_write = wr; req_super = sup; tbl_base = base;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1; req_vaddr = ~va; tbl_base = base ^ 16'h5A5A; // must be ignored
    chk(req_ready === 1'b0, "R4 busy not ready", req_ready, 0);
    chk(mem_req_valid === 1'b1, "R2 issue", mem_req_valid, 1);
    chk(mem_req_addr === exp_addr, "R2 entry addr", mem_req_addr, exp_addr);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(mem_req_valid === 1'b1 && mem_req_addr === exp_addr, "R3 hold",
          {15'b0, mem_req_valid, mem_req_addr}, {15'b0, 1'b1, exp_addr});
    end
    mem_req_ready = 1;
    @(negedge clk);
    mem_req_ready = 0;
    chk(mem_req_valid === 1'b0, "R3 single issue", mem_req_valid, 0);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk(mem_req_valid === 1'b0 && rsp_valid === 1'b0 && req_ready === 1'b0,
          "R4 wait quiet", {mem_req_valid, rsp_valid, req_ready}, 0);
    end
    mem_rsp_valid = 1; mem_rsp_data = ent;
    @(negedge clk);
    mem_rsp_valid = 0; mem_rsp_data = $urandom;
    chk(rsp_valid === 1'b1, {tag, " R9 strobe"}, rsp_valid, 1);
    chk({rsp_page_fault, rsp_prot_fault, rsp_paddr} === exp, tag,
        {rsp_page_fault, rsp_prot_fault, rsp_paddr}, exp);
    req_valid = 0; tbl_base = base;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R9 pulse", rsp_valid, 0);
    chk(req_ready === 1'b1, "R4 back idle", req_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && mem_req_valid === 1'b0 && rsp_valid === 1'b0,
        "R1 reset", {req_ready, mem_req_valid, rsp_valid}, 3'b100);
    rst_n = 1;
    // directed corners
    xlat(14'h03D4, 0, 0, 16'h0100, 16'h700D, 0, 0, "R5 absent all perms");
    xlat(14'h3FFF, 0, 0, 16'hFFFF, 16'hC02A, 4, 2, "R8 wrap read ok");
    xlat(14'h0B8F, 0, 0, 16'h0020, 16'hF011, 1, 1, "R6 user on sup page");
    xlat(14'h0B8F, 1, 1, 16'h0020, 16'hB011, 0, 3, "R6 super on sup page");
    xlat(14'h0020, 1, 0, 16'h0040, 16'hC028, 2, 0, "R7 write to ro");
    xlat(14'h0021, 0, 1, 16'h0040, 16'hA028, 0, 0, "R7 read of wo");
    xlat(14'h0021, 1, 0, 16'h0040, 16'hA028, 0, 1, "R8 write ok");
    // random mix
    for (int k = 0; k < 300; k++) begin
      logic [15:0] e;
      e = $urandom;
      if (($urandom % 4) != 0) e[15] = 1'b1;
      xlat($urandom, $urandom, $urandom, $urandom, e,
           $urandom % 4, $urandom % 4, "R8 random");
    end
    report();
  end
endmodule